// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block gathers small uncached stores aimed at a write-combining region, such as pixel writes to a frame buffer, into a single line-sized holding buffer. It then releases the gathered bytes as one burst on a bus master port. Stores that fall in the line already held are merged in place and are not forwarded. Software therefore has a window in which to add more bytes to the same line. The buffer is never snooped and takes no part in coherency, so other agents may see stale data until it drains. Combined writes may reach the bus in a different order and grouping than they were issued.

The buffer holds one 32-byte line aligned to 32 bytes, together with a 32-bit byte-valid mask. A controller with three states (`S_EMPTY`, `S_FILL`, `S_BURST`) decides when the line leaves. It moves `S_EMPTY`→`S_FILL` on *open*, when the first store lands. It moves `S_FILL`→`S_BURST` on any of four triggers: *evict* (a store to another line), *complete* (every byte valid), *fence* (flush request) or *timeout* (idle limit reached). An open store that already fills the line goes straight from `S_EMPTY` to `S_BURST`. It moves `S_BURST`→`S_EMPTY` on *retire*, when the final beat is accepted. Each burst is eight 32-bit beats carrying the line address and per-byte enables.

Top module: `wc_gather`

## Requirements
- R1: After reset `st_ready` is 1 (with `flush_req` low), `bw_valid` is 0 and `flush_done` is 0.
- R2: `st_size` encodes 0 = byte, 1 = halfword, 2 = word; 3 is treated as word. The value sits in the low bits of `st_data`. Address bits below the size's natural alignment are ignored. Byte k of the value lands at line offset (aligned offset + k).
- R3: Stores to the line already held are merged, and a later store to a byte replaces the earlier data. No bus activity occurs while the line is gathering, and the whole line leaves as exactly one burst.
- R4: A burst is eight beats at ascending 4-byte offsets. `bw_addr` equals the line base with its low 5 bits zero on every beat, and `bw_be` is that beat's 4-bit slice of the byte-valid mask. Disabled byte lanes carry zero, and `bw_last` is high only on the eighth beat.
- R5: While `bw_valid` is high and `bw_ready` is low, the beat (`bw_addr`, `bw_data`, `bw_be`, `bw_last`) stays unchanged in the next cycle.
- R6: A store to a different line while the buffer holds data keeps `st_ready` low. The burst of the held line starts in the next cycle, and the new store is accepted in the cycle right after the final beat is accepted.
- R7: A store that makes all 32 byte-valid bits set is followed by `bw_valid` in the next cycle, with no further stimulus.
- R8: While `flush_req` is high, `st_ready` is low. With data held, the line drains and `flush_done` is high in the cycle right after the final beat is accepted.
- R9: A flush with the buffer empty raises `flush_done` in the same cycle as `flush_req`.
- R10: With `idle_limit` = L ≠ 0, a held line whose last store was accepted at clock edge e starts its burst (`bw_valid` high) after edge e+L+1, with no store in between. L = 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code (R2) |
| st_data | input | 32 | Store value, low-aligned |
| flush_req | input | 1 | Fence request, held until flush_done |
| flush_done | output | 1 | Fence complete |
| idle_limit | input | 8 | Idle cycles before a timeout drain, 0 = off |
| bw_valid | output | 1 | Burst beat valid |
| bw_ready | input | 1 | Burst beat accepted |
| bw_addr | output | 32 | Line base address of the burst |
| bw_data | output | 32 | Beat data |
| bw_be | output | 4 | Beat byte enables |
| bw_last | output | 1 | Final beat of the burst |

## Verification
A store is taken on the edge where `st_valid` and `st_ready` are both high. The first beat of a full-line or evicting burst is visible one cycle after that edge. A timeout burst appears L+1 edges after the last accepted store. `flush_done` follows the final accepted beat by one cycle, or is immediate when the buffer is empty. The stimulus drives inputs and samples outputs on the falling edge, one time unit after it. The bench keeps a cycle counter and records the cycle in which it sees the final beat accepted. Eviction and fence timing are then checked as exact cycle offsets from that record, and the idle window is checked cycle by cycle against L+1.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

    // Controller states
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_FILL  = 2'd1,
        S_BURST = 2'd2
    } wcg_state_e;

    // Store size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/wcg_line_buf.sv
module wcg_line_buf
    import wcg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic                                    wr_open,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    wr_tag,
    input  logic [$clog2(LINE_BYTES)-1:0]           wr_off,
    input  logic [1:0]                              wr_size,
    input  logic [8*BEAT_BYTES-1:0]                 wr_data,
    input  logic                                    clr,
    input  logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0] rd_beat,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    tag_q,
    output logic [LINE_BYTES-1:0]                   mask_q,
    output logic                                    will_fill,
    output logic [8*BEAT_BYTES-1:0]                 rd_data,
    output logic [BEAT_BYTES-1:0]                   rd_be
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SEL_W = $clog2(BEAT_BYTES);

    logic [1:0]              sz_eff;
    logic [OFF_W:0]          nbytes;
    logic [OFF_W-1:0]        off_al;
    logic [LINE_BYTES-1:0]   lane_en;
    logic [8*LINE_BYTES-1:0] lane_bytes;
    logic [8*LINE_BYTES-1:0] byte_q;

    // Size clamp and natural alignment of the store offset
    always_comb begin
        sz_eff = (wr_size > SZ_WORD) ? SZ_WORD : wr_size;
        nbytes = (OFF_W+1)'(1) << sz_eff;
        off_al = wr_off & ~(nbytes[OFF_W-1:0] - OFF_W'(1));
    end

    // Per-byte lane steering
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        logic [OFF_W:0] pos;
        logic [OFF_W:0] rel;
        assign pos = (OFF_W+1)'(i);
        assign rel = pos - {1'b0, off_al};
        assign lane_en[i] = wr_en && (pos >= {1'b0, off_al}) && (rel < nbytes);
        assign lane_bytes[i*8 +: 8] = wr_data[rel[SEL_W-1:0]*8 +: 8];
    end

    assign will_fill = &(mask_q | lane_en);

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (lane_en[i]) byte_q[i*8 +: 8] <= lane_bytes[i*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            tag_q  <= '0;
        end else begin
            if (clr)
                mask_q <= '0;
            else
                mask_q <= mask_q | lane_en;
            if (wr_en && wr_open) tag_q <= wr_tag;
        end
    end

    // Beat read port: invalid lanes forced to zero
    always_comb begin
        for (int b = 0; b < BEAT_BYTES; b++) begin
            rd_be[b] = mask_q[{rd_beat, SEL_W'(b)}];
            rd_data[b*8 +: 8] = rd_be[b] ? byte_q[{rd_beat, SEL_W'(b)}*8 +: 8] : 8'h00;
        end
    end

    assert_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_q == '0));

    assert_openempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_open) |-> (mask_q == '0));

endmodule

// File: rtl/wcg_idle_timer.sv
module wcg_idle_timer #(
    parameter int CNT_W  = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    if (ENABLE) begin : g_on
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (!run)
                cnt_q <= '0;
            else if (cnt_q < limit)
                cnt_q <= cnt_q + 1'b1;
        end

        assign expired = run && (limit != '0) && (cnt_q == limit);

        assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (limit == '0) |-> !expired);
    end else begin : g_off
        logic unused_timer;
        assign unused_timer = ^{clk, rst_n, run, limit};
        assign expired = 1'b0;
    end

endmodule

// File: rtl/wc_gather.sv
module wc_gather
    import wcg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 4,
    parameter int IDLE_W     = 8,
    parameter bit IDLE_EN    = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [1:0]              st_size,
    input  logic [8*BEAT_BYTES-1:0] st_data,
    input  logic                    flush_req,
    output logic                    flush_done,
    input  logic [IDLE_W-1:0]       idle_limit,
    output logic                    bw_valid,
    input  logic                    bw_ready,
    output logic [ADDR_W-1:0]       bw_addr,
    output logic [8*BEAT_BYTES-1:0] bw_data,
    output logic [BEAT_BYTES-1:0]   bw_be,
    output logic                    bw_last
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
    localparam int BIDX_W = $clog2(BEATS);
    localparam logic [BIDX_W-1:0] LAST_BEAT = BIDX_W'(BEATS - 1);

    wcg_state_e            state_q, state_d;
    logic [BIDX_W-1:0]     beat_q;
    logic [TAG_W-1:0]      tag_q;
    logic [LINE_BYTES-1:0] mask_q;
    logic                  will_fill;
    logic                  hit;
    logic                  accept;
    logic                  retire;
    logic                  idle_run;
    logic                  idle_exp;

    assign hit      = (st_addr[ADDR_W-1:OFF_W] == tag_q);
    assign accept   = st_valid && st_ready;
    assign retire   = (state_q == S_BURST) && bw_ready && (beat_q == LAST_BEAT);
    assign idle_run = (state_q == S_FILL) && !st_valid && !flush_req;

    wcg_line_buf #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_open   (state_q == S_EMPTY),
        .wr_tag    (st_addr[ADDR_W-1:OFF_W]),
        .wr_off    (st_addr[OFF_W-1:0]),
        .wr_size   (st_size),
        .wr_data   (st_data),
        .clr       (retire),
        .rd_beat   (beat_q),
        .tag_q     (tag_q),
        .mask_q    (mask_q),
        .will_fill (will_fill),
        .rd_data   (bw_data),
        .rd_be     (bw_be)
    );

    wcg_idle_timer #(
        .CNT_W  (IDLE_W),
        .ENABLE (IDLE_EN)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (idle_run),
        .limit   (idle_limit),
        .expired (idle_exp)
    );

    // State and beat registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_BURST && bw_ready)
                beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
        end
    end

    // Transitions: open, complete, evict, fence, timeout, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (accept) state_d = will_fill ? S_BURST : S_FILL;
            end
            S_FILL: begin
                if (accept && will_fill)
                    state_d = S_BURST;
                else if (flush_req || (st_valid && !hit) || idle_exp)
                    state_d = S_BURST;
            end
            S_BURST: begin
                if (retire) state_d = S_EMPTY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        st_ready   = 1'b0;
        flush_done = 1'b0;
        bw_valid   = 1'b0;
        bw_last    = 1'b0;
        unique case (state_q)
            S_EMPTY: begin
                st_ready   = !flush_req;
                flush_done = flush_req;
            end
            S_FILL: begin
                st_ready = !flush_req && hit;
            end
            S_BURST: begin
                bw_valid = 1'b1;
                bw_last  = (beat_q == LAST_BEAT);
            end
            default: ;
        endcase
        bw_addr = {tag_q, OFF_W'(0)};
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_data) && $stable(bw_be)
                                     && $stable(bw_addr) && $stable(bw_last)));

    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> !st_ready);

    assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mask_q) == LINE_BYTES) |-> bw_valid);

    assert_fence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !st_ready);

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (!bw_valid && mask_q == '0));

    assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_ready && bw_last) |=> !bw_valid);

endmodule

// File: tb/sim_wc_gather.sv
`timescale 1ns/1ps
module sim_wc_gather;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic        flush_req = 1'b0;
    logic        flush_done;
    logic [7:0]  idle_limit = '0;
    logic        bw_valid;
    logic        bw_ready = 1'b1;
    logic [31:0] bw_addr;
    logic [31:0] bw_data;
    logic [3:0]  bw_be;
    logic        bw_last;

    wc_gather u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data),
        .flush_req(flush_req), .flush_done(flush_done), .idle_limit(idle_limit),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_be(bw_be), .bw_last(bw_last)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int stall_mode = 0;
    int last_beat_cyc = -10;
    bit finished = 0;

    // Reference line model
    bit          m_open = 0;
    logic [26:0] m_tag = '0;
    logic [255:0] m_data = '0;
    logic [31:0] m_mask = '0;
    logic [31:0]  q_addr[$];
    logic [255:0] q_data[$];
    logic [31:0]  q_mask[$];
    string        q_tag[$];

    // Monitor state
    int          bidx = 0;
    bit          held = 0;
    bit          addr_bad = 0;
    bit          last_bad = 0;
    logic [31:0] cur_addr;
    logic [255:0] cur_data;
    logic [31:0] cur_mask;
    logic [31:0] h_addr, h_data;
    logic [3:0]  h_be;
    logic        h_last;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] line_of(input logic [26:0] t);
        return {t, 5'b0};
    endfunction

    task automatic m_drain(input string tg);
        if (m_open) begin
            q_addr.push_back(line_of(m_tag));
            q_data.push_back(m_data);
            q_mask.push_back(m_mask);
            q_tag.push_back(tg);
        end
        m_open = 0;
        m_data = '0;
        m_mask = '0;
    endtask

    // R2 placement rule
    task automatic m_store(input logic [31:0] a, input logic [1:0] s,
                           input logic [31:0] d, input string tg);
        int nb;
        int off;
        logic [1:0] se;
        se = (s == 2'd3) ? 2'd2 : s;
        if (!m_open) begin
            m_open = 1;
            m_tag = a[31:5];
        end
        nb = 1 << se;
        off = int'(a[4:0]) & ~(nb - 1);
        for (int k = 0; k < nb; k++) begin
            m_data[(off + k)*8 +: 8] = d[k*8 +: 8];
            m_mask[off + k] = 1'b1;
        end
        if (&m_mask) m_drain(tg);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] s,
                            input logic [31:0] d, input string tg);
        if (m_open && a[31:5] != m_tag) m_drain(tg);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_size = s; st_data = d;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        m_store(a, s, d, tg);
        #1 st_valid = 0;
    endtask

    task automatic do_flush(input string tg);
        bit was_open;
        was_open = m_open;
        m_drain(tg);
        @(negedge clk);
        flush_req = 1;
        #1;
        chk(st_ready == 1'b0, "R8", "st_ready under fence", 256'(st_ready), 256'(0));
        if (!was_open) begin
            chk(flush_done == 1'b1, "R9", "empty fence done", 256'(flush_done), 256'(1));
        end else begin
            while (!flush_done) begin
                @(negedge clk);
                #1;
            end
            chk(cyc == last_beat_cyc + 1, "R8", "fence done cycle",
                256'(cyc), 256'(last_beat_cyc + 1));
        end
        @(posedge clk);
        #1 flush_req = 0;
    endtask

    // Bus side: backpressure, capture, beat hold check
    task automatic bus_step();
        if (held)
            chk(bw_valid && bw_data == h_data && bw_be == h_be && bw_addr == h_addr
                && bw_last == h_last, "R5", "beat held under stall",
                256'({bw_valid, bw_addr, bw_data, bw_be}), 256'({1'b1, h_addr, h_data, h_be}));
        case (stall_mode)
            0: bw_ready = 1'b1;
            1: bw_ready = ($urandom % 3) != 0;
            default: bw_ready = 1'b0;
        endcase
        held = bw_valid && !bw_ready;
        h_addr = bw_addr; h_data = bw_data; h_be = bw_be; h_last = bw_last;
        if (bw_valid && bw_ready) begin
            if (bidx == 0) cur_addr = bw_addr;
            else if (bw_addr != cur_addr) addr_bad = 1;
            cur_data[bidx*32 +: 32] = bw_data;
            cur_mask[bidx*4 +: 4] = bw_be;
            if (bw_last != (bidx == 7)) last_bad = 1;
            if (bidx == 7) begin
                last_beat_cyc = cyc;
                if (q_addr.size() == 0) begin
                    chk(0, "R3", "unexpected burst", 256'(cur_addr), 256'(0));
                end else begin
                    string tg;
                    logic [31:0] ea;
                    logic [255:0] ed;
                    logic [31:0] em;
                    ea = q_addr.pop_front(); ed = q_data.pop_front();
                    em = q_mask.pop_front(); tg = q_tag.pop_front();
                    chk(!addr_bad && !last_bad && cur_addr == ea, "R4",
                        {tg, " burst address/last"}, 256'({last_bad, addr_bad, cur_addr}), 256'(ea));
                    chk(cur_data == ed, "R4", {tg, " burst data"}, cur_data, ed);
                    chk(cur_mask == em, "R4", {tg, " burst enables"}, 256'(cur_mask), 256'(em));
                end
                bidx = 0; addr_bad = 0; last_bad = 0;
            end else begin
                bidx++;
            end
        end
    endtask

    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            bus_step();
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run did not end", 256'(cyc), 256'(0));
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(st_ready == 1'b1, "R1", "st_ready after reset", 256'(st_ready), 256'(1));
        chk(bw_valid == 1'b0, "R1", "bw_valid after reset", 256'(bw_valid), 256'(0));
        chk(flush_done == 1'b0, "R1", "flush_done after reset", 256'(flush_done), 256'(0));

        // R9 fence on empty buffer
        do_flush("R9");

        // R2 sizes and alignment
        do_store(32'h0000_1003, 2'd1, 32'h0000_BEEF, "R2");
        do_store(32'h0000_1006, 2'd2, 32'h1122_3344, "R2");
        do_store(32'h0000_1001, 2'd0, 32'h0000_005A, "R2");
        do_store(32'h0000_101B, 2'd3, 32'hCAFE_F00D, "R2");
        do_flush("R2");

        // R3 overwrite and quiet gathering
        do_store(32'h0000_2000, 2'd0, 32'h11, "R3");
        do_store(32'h0000_2000, 2'd0, 32'h22, "R3");
        do_store(32'h0000_201F, 2'd0, 32'h33, "R3");
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            #1;
            chk(bw_valid == 1'b0, "R3", "no bus while gathering", 256'(bw_valid), 256'(0));
        end
        do_flush("R3");

        // R7 full line
        for (int w = 0; w < 8; w++)
            do_store(32'h0000_5000 + 32'(w*4), 2'd2, 32'hA0A0_0000 + 32'(w), "R7");
        @(negedge clk);
        #1;
        chk(bw_valid == 1'b1, "R7", "burst after full line", 256'(bw_valid), 256'(1));
        repeat (12) @(negedge clk);

        // R6 eviction with backpressure
        do_store(32'h0000_6004, 2'd1, 32'h0000_7777, "R6");
        m_drain("R6");
        @(negedge clk);
        stall_mode = 2;
        st_valid = 1; st_addr = 32'h0000_6020; st_size = 2'd2; st_data = 32'h0BAD_CAFE;
        #1;
        chk(st_ready == 1'b0, "R6", "miss stalled", 256'(st_ready), 256'(0));
        @(negedge clk);
        #1;
        chk(bw_valid == 1'b1, "R6", "evict burst next cycle", 256'(bw_valid), 256'(1));
        repeat (4) begin
            @(negedge clk);
            #1;
            chk(st_ready == 1'b0, "R6", "miss held during burst", 256'(st_ready), 256'(0));
        end
        stall_mode = 0;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        chk(cyc == last_beat_cyc + 1, "R6", "miss accept cycle",
            256'(cyc), 256'(last_beat_cyc + 1));
        @(posedge clk);
        m_store(32'h0000_6020, 2'd2, 32'h0BAD_CAFE, "R6");
        #1 st_valid = 0;
        do_flush("R6");

        // R10 idle timeout
        idle_limit = 8'd5;
        do_store(32'h0000_3008, 2'd2, 32'h1357_9BDF, "R10");
        m_drain("R10");
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            #1;
            chk(bw_valid == (k == 6), "R10", $sformatf("idle window step %0d", k),
                256'(bw_valid), 256'(k == 6));
        end
        repeat (12) @(negedge clk);
        idle_limit = 8'd0;

        // Random phase across three lines with random backpressure
        stall_mode = 1;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            a = 32'h0000_4000 + 32'(($urandom % 3) * 32) + 32'($urandom % 32);
            do_store(a, 2'($urandom % 4), $urandom, "R3");
            if ($urandom % 25 == 0) do_flush("R8");
        end
        do_flush("R8");
        stall_mode = 0;
        repeat (30) @(negedge clk);
        chk(q_addr.size() == 0, "R4", "all expected bursts seen", 256'(q_addr.size()), 256'(0));
        finish_run();
    end

endmodule